// File: doc/BRIEF.md
# Dual-Processor Doorbell Controller

This block lets two processors signal each other over six one-way channels. Each processor owns one flag per channel. When a processor raises its flag, it hands a message on that channel to the other side. The receiving processor lowers the flag to report that the channel is free again. Message storage lives elsewhere; this block carries only the occupied/free handshake and the interrupts that go with it.

Both processors reach the block over one synchronous register bus. A select input says which processor's register window an access targets. Each window holds four registers:

- a control word with two global interrupt enables,
- a mask word with two per-channel masks,
- a write-one set/clear word,
- a status word showing the flags that processor owns.

Each processor receives two level interrupts. The receive interrupt reports that the other side has occupied a channel. The transmit interrupt reports that one of its own channels is free.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, all flags are 0 and both interrupt enables of both processors are 0. All mask bits are 1, so the mask word reads 0x003F003F. All four interrupt outputs are 0.
- R2: A write to offset 0x8 with bit 16+n set raises the writing processor's own flag n. Bits written as 0 change no flag. Writes to any other offset change no flag.
- R3: A write to offset 0x8 with bit n set lowers flag n owned by the other processor. The writer's own flag n is left unchanged.
- R4: A read of offset 0xC returns the flags owned by the selected processor in bits 0 to 5. All other bits read 0.
- R5: The control word at offset 0x0 holds the receive enable in bit 0 and the transmit enable in bit 1. It reads back as written, with the other bits 0.
- R6: The mask word at offset 0x4 holds the occupied mask in bits 0 to 5 and the free mask in bits 16 to 21. A mask bit of 1 disables that channel. The word reads back as written, with the other bits 0.
- R7: The receive interrupt of processor p is set when p's receive enable is 1 and some channel n has the other processor's flag n at 1 while p's occupied mask bit n is 0.
- R8: The transmit interrupt of processor p is set when p's transmit enable is 1 and some channel n has p's own flag n at 0 while p's free mask bit n is 0.
- R9: The interrupt outputs are registered. They change on the clock edge after the flag, mask or enable change that causes them.
- R10: Read data appears on the bus the cycle after the read. Offset 0x8 reads as 0. Writes to offset 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | Processor window selected: 0 or 1 |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_rx | output | 2 | Receive-occupied interrupt, one bit per processor |
| irq_tx | output | 2 | Transmit-free interrupt, one bit per processor |

## Verification
The hardest case to reach is a precise mix: one processor's flags against the other processor's masks, with some channels masked and some not, under each of the four enable combinations. A single wrong pairing of owner and observer can hide behind another channel that happens to hold the interrupt at the same level.

The bench works through this mix systematically. For each of the four enable combinations it loads a different pair of mask patterns. It then walks all 64 flag patterns of processor 0, and derives the pattern for processor 1 from the loop index. Both sides are cleared by cross-processor clears before each pattern is set.

A separate step holds every channel full and then frees one channel. It watches the transmit interrupt and checks that it stays low for one cycle before rising.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int NUM_CPU     = 2;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int SET_LSB     = 16;
    localparam int CLR_LSB     = 0;
    localparam int OCC_LSB     = 0;
    localparam int FREE_LSB    = 16;
    localparam int CTRL_RX_BIT = 0;
    localparam int CTRL_TX_BIT = 1;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_MASK   = 2'd1,
        REG_SETCLR = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbox_cfg_regs.sv
module mbox_cfg_regs
    import mbox_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_rx,
    output logic              en_tx,
    output logic [NCH-1:0]    occ_mask,
    output logic [NCH-1:0]    free_mask
);
    typedef struct packed {
        logic           en_rx;
        logic           en_tx;
        logic [NCH-1:0] occ;
        logic [NCH-1:0] free;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en_rx = wdata[CTRL_RX_BIT];
            st_d.en_tx = wdata[CTRL_TX_BIT];
        end
        if (wr_mask) begin
            st_d.occ  = wdata[OCC_LSB +: NCH];
            st_d.free = wdata[FREE_LSB +: NCH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en_rx: 1'b0, en_tx: 1'b0, occ: '1, free: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_rx     = st_q.en_rx;
    assign en_tx     = st_q.en_tx;
    assign occ_mask  = st_q.occ;
    assign free_mask = st_q.free;

    logic unused_wdata;
    assign unused_wdata = ^wdata;
endmodule

// File: rtl/mbox_flag_bank.sv
module mbox_flag_bank
    import mbox_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_setclr,
    input  logic                          sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_CPU-1:0][NCH-1:0]   flags
);
    typedef struct packed {
        logic [NUM_CPU-1:0][NCH-1:0] own;
    } flag_t;

    flag_t st_d, st_q;
    logic [NUM_CPU-1:0][NCH-1:0] set_v;
    logic [NUM_CPU-1:0][NCH-1:0] clr_v;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            set_v[c] = (wr_setclr && (sel == 1'(c))) ? wdata[SET_LSB +: NCH] : '0;
            clr_v[c] = (wr_setclr && (sel != 1'(c))) ? wdata[CLR_LSB +: NCH] : '0;
            st_d.own[c] = (st_q.own[c] & ~clr_v[c]) | set_v[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.own;

    logic unused_wdata;
    assign unused_wdata = ^wdata;
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen
    import mbox_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CPU-1:0][NCH-1:0] flags,
    input  logic [NUM_CPU-1:0][NCH-1:0] occ_mask,
    input  logic [NUM_CPU-1:0][NCH-1:0] free_mask,
    input  logic [NUM_CPU-1:0]          en_rx,
    input  logic [NUM_CPU-1:0]          en_tx,
    output logic [NUM_CPU-1:0]          irq_rx,
    output logic [NUM_CPU-1:0]          irq_tx
);
    typedef struct packed {
        logic [NUM_CPU-1:0] rx;
        logic [NUM_CPU-1:0] tx;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            st_d.rx[c] = en_rx[c] && (|(flags[NUM_CPU-1-c] & ~occ_mask[c]));
            st_d.tx[c] = en_tx[c] && (|(~flags[c] & ~free_mask[c]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_rx = st_q.rx;
    assign irq_tx = st_q.tx;
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq_rx,
    output logic [1:0]        irq_tx
);
    reg_sel_e                    reg_idx;
    logic                        wr_any;
    logic [NUM_CPU-1:0][NCH-1:0] flags;
    logic [NUM_CPU-1:0][NCH-1:0] occ_v;
    logic [NUM_CPU-1:0][NCH-1:0] free_v;
    logic [NUM_CPU-1:0]          en_rx_v;
    logic [NUM_CPU-1:0]          en_tx_v;

    assign reg_idx = reg_sel_e'(bus_addr[3:2]);
    assign wr_any  = bus_en && bus_we;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic hit;
        assign hit = wr_any && (bus_sel == 1'(c));
        mbox_cfg_regs #(.NCH(NCH)) u_cfg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (hit && (reg_idx == REG_CTRL)),
            .wr_mask   (hit && (reg_idx == REG_MASK)),
            .wdata     (bus_wdata),
            .en_rx     (en_rx_v[c]),
            .en_tx     (en_tx_v[c]),
            .occ_mask  (occ_v[c]),
            .free_mask (free_v[c])
        );
    end

    mbox_flag_bank #(.NCH(NCH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_setclr (wr_any && (reg_idx == REG_SETCLR)),
        .sel       (bus_sel),
        .wdata     (bus_wdata),
        .flags     (flags)
    );

    mbox_irq_gen #(.NCH(NCH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .occ_mask  (occ_v),
        .free_mask (free_v),
        .en_rx     (en_rx_v),
        .en_tx     (en_tx_v),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    // Registered read path
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_en && !bus_we) begin
            rd_d.rdata = '0;
            unique case (reg_idx)
                REG_CTRL: begin
                    rd_d.rdata[CTRL_RX_BIT] = en_rx_v[bus_sel];
                    rd_d.rdata[CTRL_TX_BIT] = en_tx_v[bus_sel];
                end
                REG_MASK: begin
                    rd_d.rdata[OCC_LSB +: NCH]  = occ_v[bus_sel];
                    rd_d.rdata[FREE_LSB +: NCH] = free_v[bus_sel];
                end
                REG_SETCLR: rd_d.rdata = '0;
                REG_STAT:   rd_d.rdata[NCH-1:0] = flags[bus_sel];
                default:    rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    logic unused_addr;
    assign unused_addr = ^bus_addr[1:0];
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk #(
    parameter int NCH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic              bus_sel,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [1:0]        irq_rx,
    input logic [1:0]        irq_tx,
    input logic [1:0][NCH-1:0] own_flags,
    input logic [1:0][NCH-1:0] occ_mask,
    input logic [1:0][NCH-1:0] free_mask,
    input logic [1:0]        en_rx,
    input logic [1:0]        en_tx
);
    logic wr_sc;
    assign wr_sc = bus_en && bus_we && (bus_addr[3:2] == 2'd2);

    // R1: while reset is held, flags and interrupts stay cleared
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (own_flags == '0 && irq_rx == 2'b00 && irq_tx == 2'b00));

    // R2: flags only move on a set/clear write
    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sc |=> $stable(own_flags));

    for (genvar s = 0; s < 2; s++) begin : g_side
        // R7, R9: receive interrupt follows the other side's flags one cycle later
        assert_rx_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq_rx[s] == $past(en_rx[s] && (|(own_flags[1-s] & ~occ_mask[s]))));
        // R8, R9: transmit interrupt follows the own flags one cycle later
        assert_tx_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq_tx[s] == $past(en_tx[s] && (|(~own_flags[s] & ~free_mask[s]))));
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            // R2: set bit raises the writer's own flag
            assert_set_own_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_sc && bus_sel == 1'(s) && bus_wdata[16+i]) |=> own_flags[s][i]);
            // R3: clear bit lowers the other side's flag
            assert_clear_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_sc && bus_sel == 1'(s) && bus_wdata[i]) |=> !own_flags[1-s][i]);
        end
    end
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .own_flags (flags),
    .occ_mask  (occ_v),
    .free_mask (free_v),
    .en_rx     (en_rx_v),
    .en_tx     (en_tx_v)
);

// File: tb/mbox_doorbell_tb.sv
`timescale 1ns/100ps
module mbox_doorbell_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_rx;
    logic [1:0]  irq_tx;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // model of the programmer-visible state
    logic [5:0] mf  [2];
    logic [5:0] mom [2];
    logic [5:0] mfm [2];
    logic       mer [2];
    logic       met [2];

    always #2.5 clk = ~clk;

    mbox_doorbell u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_sel = s; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        case (a[3:2])
            2'd0: begin mer[s] = d[0]; met[s] = d[1]; end
            2'd1: begin mom[s] = d[5:0]; mfm[s] = d[21:16]; end
            2'd2: begin
                mf[s]  = mf[s] | d[21:16];
                mf[~s] = mf[~s] & ~d[5:0];
            end
            default: ;
        endcase
    endtask

    task automatic rd(input logic s, input logic [3:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_sel = s; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic exp_rx(input int c);
        return mer[c] && (|(mf[1-c] & ~mom[c]));
    endfunction

    function automatic logic exp_tx(input int c);
        return met[c] && (|(~mf[c] & ~mfm[c]));
    endfunction

    task automatic check_all(input string ctx);
        logic [31:0] v;
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            chk({"R7 rx irq ", ctx}, 32'(irq_rx[c]), 32'(exp_rx(c)));
            chk({"R8 tx irq ", ctx}, 32'(irq_tx[c]), 32'(exp_tx(c)));
            rd(c[0], 4'hC, v);
            chk({"R4 status ", ctx}, v, {26'd0, mf[c]});
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < 2; c++) begin
            mf[c] = '0; mom[c] = '1; mfm[c] = '1; mer[c] = 1'b0; met[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_rx", 32'(irq_rx), 32'd0);
        chk("R1 irq_tx", 32'(irq_tx), 32'd0);
        for (int c = 0; c < 2; c++) begin
            rd(c[0], 4'h0, v); chk("R1 ctrl", v, 32'd0);
            rd(c[0], 4'h4, v); chk("R1 mask", v, 32'h003F_003F);
            rd(c[0], 4'hC, v); chk("R1 status", v, 32'd0);
        end

        // R5 / R6: readback of control and mask
        wr(1'b0, 4'h0, 32'hFFFF_FFFE); rd(1'b0, 4'h0, v); chk("R5 ctrl cpu0", v, 32'd2);
        wr(1'b1, 4'h0, 32'h0000_0001); rd(1'b1, 4'h0, v); chk("R5 ctrl cpu1", v, 32'd1);
        rd(1'b0, 4'h0, v); chk("R5 ctrl cpu0 kept", v, 32'd2);
        wr(1'b0, 4'h4, 32'hFFEA_FF15); rd(1'b0, 4'h4, v); chk("R6 mask cpu0", v, 32'h002A_0015);
        wr(1'b1, 4'h4, 32'h0013_002C); rd(1'b1, 4'h4, v); chk("R6 mask cpu1", v, 32'h0013_002C);

        // R10: status is read-only, set/clear reads zero
        wr(1'b0, 4'hC, 32'hFFFF_FFFF);
        check_all("R10 status write ignored");
        wr(1'b0, 4'h8, 32'h0009_0000);
        rd(1'b0, 4'h8, v); chk("R10 setclr reads zero", v, 32'd0);
        check_all("R2 set 0x09");
        wr(1'b0, 4'h8, 32'h0000_0000);
        check_all("R2 zero write");
        wr(1'b1, 4'h8, 32'h0000_0001);
        check_all("R3 clear ch0 by cpu1");

        // Sweep: enable combos x masks x flag patterns (R2, R3, R4, R7, R8)
        for (int k = 0; k < 4; k++) begin
            wr(1'b0, 4'h0, 32'(k));
            wr(1'b1, 4'h0, 32'(3 - k));
            wr(1'b0, 4'h4, {10'd0, 6'((k * 13 + 5) & 63), 10'd0, 6'((k * 21 + 3) & 63)});
            wr(1'b1, 4'h4, {10'd0, 6'((k * 19 + 9) & 63), 10'd0, 6'((k * 7 + 40) & 63)});
            for (int p = 0; p < 64; p++) begin
                wr(1'b1, 4'h8, 32'h0000_003F);
                wr(1'b0, 4'h8, 32'h0000_003F);
                wr(1'b0, 4'h8, {10'd0, 6'(p), 16'd0});
                wr(1'b1, 4'h8, {10'd0, 6'((p * 11 + k) & 63), 10'd0, 6'(p ^ 6'h2A)});
                check_all("sweep");
            end
        end

        // R9: interrupt lags the causing flag change by one cycle
        wr(1'b0, 4'h0, 32'd2);
        wr(1'b0, 4'h4, 32'h003E_003F);
        wr(1'b0, 4'h8, 32'h003F_0000);
        check_all("R9 setup");
        wr(1'b1, 4'h8, 32'h0000_0001);
        chk("R9 tx still low one cycle after", 32'(irq_tx[0]), 32'd0);
        @(negedge clk);
        chk("R9 tx high two cycles after", 32'(irq_tx[0]), 32'd1);
        wr(1'b0, 4'h4, 32'h003F_003F);
        chk("R9 tx high right after mask write", 32'(irq_tx[0]), 32'd1);
        @(negedge clk);
        chk("R9 tx low after mask settles", 32'(irq_tx[0]), 32'd0);

        done = 1'b1;
        report();
    end
endmodule